// File: doc/BRIEF.md
# Light-Load Sleep and Burst Detector

This block sits in the secondary-side rectifier controller and decides, cycle by cycle, whether the gate driver may switch the rectifier transistor. It uses two inputs to make that decision. The first is the conduction time measured for each switching cycle, reported as a one-clock sample. The second is a level that is high while the drain voltage is below the cycle threshold. From these it detects two light-load conditions, each with its own way back to normal driving:

- A too-short conduction cycle sends the block to sleep.
- A long switching stop, meaning a burst pause on the primary side, sends it to burst.

The sleep thresholds form a hysteresis band. Both edges of the band are derived from the programmed minimum on-time plus a fixed offset. The upper edge adds one fifth of the on-time, computed as an integer division. After a resume from burst, the first conduction cycle is not driven, and the second is driven with the minimum width. After the start-up strap phase, the block begins asleep. All times are in clock cycles.

Top module: `slp_burst_ctrl`

## Requirements
- R1: While rst_ni is low and until strap_done_i is seen high, outputs are drive_en_o=0, skip_cycle_o=0, force_min_o=0 and mode_o=1. Conduction samples have no effect in this phase. Mode encoding is 0 run, 1 sleep, 2 burst, 3 sleep-then-burst.
- R2: One clock edge with strap_done_i high moves the block to sleep (mode_o=1, drive_en_o=0). Drain edges alone never enable driving from there.
- R3: In run, a sample with cond_time_i <= ton_min_i + OFF_CYC moves the block to sleep on that edge, with drive_en_o=0. A sample one clock longer keeps it in run.
- R4: In sleep, a sample with cond_time_i > ton_min_i + ton_min_i/5 + OFF_CYC (integer division) returns the block to run with drive_en_o=1. A sample equal to that bound keeps it asleep.
- R5: In run, STOP_CYC consecutive clock edges with drain_low_i low move the block to burst (mode_o=2, drive_en_o=0). STOP_CYC-1 such edges do not. Any clock with drain_low_i high restarts the count.
- R6: In burst, the next rise of drain_low_i gives mode_o=0, skip_cycle_o=1 and drive_en_o=0 until drain_low_i falls. Then force_min_o=1 with drive_en_o=1 until the following fall of drain_low_i. After that the block is in plain run.
- R7: In sleep, an expired stop interval gives mode_o=3. Only a sample above the R4 bound leaves this mode, and it goes to run.
- R8: When the stop interval expires on the same edge as a qualifying sample, the stop wins. In run the block goes to burst; in sleep it goes to mode 3.
- R9: Conduction samples have no effect during burst and during the skipped and minimum-width resume cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_done_i | input | 1 | Start-up strap phase finished |
| drain_low_i | input | 1 | Drain voltage below the cycle threshold |
| cond_valid_i | input | 1 | One-clock strobe: cond_time_i holds a new sample |
| cond_time_i | input | TW | Conduction time of the last cycle, in clocks |
| ton_min_i | input | TW | Programmed minimum on-time, in clocks (static) |
| drive_en_o | output | 1 | Gate driving allowed |
| skip_cycle_o | output | 1 | Current cycle must not be driven |
| force_min_o | output | 1 | Current cycle is driven with the minimum width |
| mode_o | output | 2 | 0 run, 1 sleep, 2 burst, 3 sleep-then-burst |

## Verification
Two functions can land on the same clock edge: expiry of the stop interval, and a conduction sample that qualifies for a mode change. The bench provokes this by holding the drain high for one clock fewer than the stop interval and then strobing a sample on the expiring edge. It does this twice: once in run with a short sample, and once in sleep with a long sample. Each case is judged by the mode and drive flags one edge later. Burst must win in run, and sleep-then-burst must win in sleep.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    MODE_RUN       = 2'd0,
    MODE_SLEEP     = 2'd1,
    MODE_BURST     = 2'd2,
    MODE_SLP_BURST = 2'd3
  } slp_mode_e;

  typedef enum logic [2:0] {
    ST_STRAP,
    ST_RUN,
    ST_SLEEP,
    ST_BURST,
    ST_SLP_BURST,
    ST_SKIP,
    ST_MINW
  } slp_state_e;
endpackage

// File: rtl/slp_thresh.sv
module slp_thresh #(
  parameter int TW      = 16,
  parameter int OFF_CYC = 15,
  parameter bit THR_REG = 1'b1,
  localparam int XW     = TW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] ton_i,
  output logic [XW-1:0] enter_o,
  output logic [XW-1:0] exit_o
);
  localparam logic [XW-1:0] OFF = XW'(OFF_CYC);

  logic [XW-1:0] ton_x, fifth_x, enter_d, exit_d;

  always_comb begin
    ton_x   = {2'b00, ton_i};
    fifth_x = {2'b00, ton_i / TW'(5)};
    enter_d = ton_x + OFF;
    exit_d  = ton_x + fifth_x + OFF;
  end

  generate
    if (THR_REG) begin : g_reg
      logic [XW-1:0] enter_q, exit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          enter_q <= '0;
          exit_q  <= '0;
        end else begin
          enter_q <= enter_d;
          exit_q  <= exit_d;
        end
      end
      assign enter_o = enter_q;
      assign exit_o  = exit_q;
    end else begin : g_comb
      assign enter_o = enter_d;
      assign exit_o  = exit_d;
    end
  endgenerate
endmodule

// File: rtl/slp_stop_timer.sv
module slp_stop_timer #(
  parameter int STOP_CYC = 6000,
  localparam int CW      = $clog2(STOP_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drain_low_i,
  output logic stop_o,
  output logic drain_fall_o,   // drain drops below threshold
  output logic drain_rise_o    // drain climbs back above threshold
);
  localparam logic [CW-1:0] LAST = CW'(STOP_CYC - 1);
  localparam logic [CW-1:0] SAT  = CW'(STOP_CYC);

  logic          low_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      low_q <= drain_low_i;
      if (drain_low_i)       cnt_q <= '0;
      else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stop_o       = !drain_low_i && (cnt_q >= LAST);
  assign drain_fall_o = drain_low_i && !low_q;
  assign drain_rise_o = !drain_low_i && low_q;
endmodule

// File: rtl/slp_mode_fsm.sv
module slp_mode_fsm
  import slp_pkg::*;
#(
  parameter int TW = 16,
  localparam int XW = TW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_done_i,
  input  logic          cond_valid_i,
  input  logic [TW-1:0] cond_time_i,
  input  logic [XW-1:0] enter_thr_i,
  input  logic [XW-1:0] exit_thr_i,
  input  logic          stop_i,
  input  logic          drain_fall_i,
  input  logic          drain_rise_i,
  output logic          drive_en_o,
  output logic          skip_cycle_o,
  output logic          force_min_o,
  output slp_mode_e     mode_o
);
  slp_state_e st_q, st_d;
  logic       is_short, is_long;

  assign is_short = cond_valid_i && ({2'b00, cond_time_i} <= enter_thr_i);
  assign is_long  = cond_valid_i && ({2'b00, cond_time_i} >  exit_thr_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_STRAP:     if (strap_done_i) st_d = ST_SLEEP;
      ST_RUN:       if (stop_i) st_d = ST_BURST;
                    else if (is_short) st_d = ST_SLEEP;
      ST_SLEEP:     if (stop_i) st_d = ST_SLP_BURST;
                    else if (is_long) st_d = ST_RUN;
      ST_SLP_BURST: if (is_long) st_d = ST_RUN;
      ST_BURST:     if (drain_fall_i) st_d = ST_SKIP;
      ST_SKIP:      if (stop_i) st_d = ST_BURST;
                    else if (drain_rise_i) st_d = ST_MINW;
      ST_MINW:      if (stop_i) st_d = ST_BURST;
                    else if (drain_rise_i) st_d = ST_RUN;
      default:      st_d = ST_STRAP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_STRAP;
    else         st_q <= st_d;
  end

  always_comb begin
    drive_en_o   = (st_q == ST_RUN) || (st_q == ST_MINW);
    skip_cycle_o = (st_q == ST_SKIP);
    force_min_o  = (st_q == ST_MINW);
    unique case (st_q)
      ST_RUN, ST_SKIP, ST_MINW: mode_o = MODE_RUN;
      ST_BURST:                 mode_o = MODE_BURST;
      ST_SLP_BURST:             mode_o = MODE_SLP_BURST;
      default:                  mode_o = MODE_SLEEP;
    endcase
  end
endmodule

// File: rtl/slp_burst_ctrl.sv
module slp_burst_ctrl
  import slp_pkg::*;
#(
  parameter int TW       = 16,
  parameter int STOP_CYC = 6000,
  parameter int OFF_CYC  = 15,
  parameter bit THR_REG  = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_done_i,
  input  logic          drain_low_i,
  input  logic          cond_valid_i,
  input  logic [TW-1:0] cond_time_i,
  input  logic [TW-1:0] ton_min_i,
  output logic          drive_en_o,
  output logic          skip_cycle_o,
  output logic          force_min_o,
  output logic [1:0]    mode_o
);
  localparam int XW = TW + 2;

  logic [XW-1:0] enter_thr, exit_thr;
  logic          stop, drain_fall, drain_rise;
  slp_mode_e     mode;

  slp_thresh #(.TW(TW), .OFF_CYC(OFF_CYC), .THR_REG(THR_REG)) u_thr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ton_i   (ton_min_i),
    .enter_o (enter_thr),
    .exit_o  (exit_thr)
  );

  slp_stop_timer #(.STOP_CYC(STOP_CYC)) u_tmr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .drain_low_i  (drain_low_i),
    .stop_o       (stop),
    .drain_fall_o (drain_fall),
    .drain_rise_o (drain_rise)
  );

  slp_mode_fsm #(.TW(TW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strap_done_i (strap_done_i),
    .cond_valid_i (cond_valid_i),
    .cond_time_i  (cond_time_i),
    .enter_thr_i  (enter_thr),
    .exit_thr_i   (exit_thr),
    .stop_i       (stop),
    .drain_fall_i (drain_fall),
    .drain_rise_i (drain_rise),
    .drive_en_o   (drive_en_o),
    .skip_cycle_o (skip_cycle_o),
    .force_min_o  (force_min_o),
    .mode_o       (mode)
  );

  assign mode_o = mode;
endmodule

// File: rtl/slp_burst_ctrl_chk.sv
module slp_burst_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       drain_low_i,
  input logic       cond_valid_i,
  input logic       drive_en_o,
  input logic       skip_cycle_o,
  input logic       force_min_o,
  input logic [1:0] mode_o
);
  localparam logic [1:0] M_RUN = 2'd0, M_SLP = 2'd1, M_BST = 2'd2, M_SB = 2'd3;

  AST_SLEEP_NEEDS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_SLP && !cond_valid_i) |=> !drive_en_o); // R4

  AST_RUN_SLEEP_NEEDS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_RUN && !cond_valid_i) |=> mode_o != M_SLP); // R3

  AST_SLPBURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_SB && !cond_valid_i) |=> mode_o == M_SB); // R7

  AST_BURST_ON_HIGH_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_BST && $past(mode_o) != M_BST) |-> $past(!drain_low_i)); // R5

  AST_SKIP_FROM_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(skip_cycle_o) |-> $past(mode_o) == M_BST); // R6

  AST_SKIP_THEN_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(skip_cycle_o) |-> (force_min_o || mode_o == M_BST)); // R6

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({skip_cycle_o, force_min_o})); // R6
endmodule

bind slp_burst_ctrl slp_burst_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .drain_low_i  (drain_low_i),
  .cond_valid_i (cond_valid_i),
  .drive_en_o   (drive_en_o),
  .skip_cycle_o (skip_cycle_o),
  .force_min_o  (force_min_o),
  .mode_o       (mode_o)
);

// File: tb/tb_slp_burst_ctrl.sv
module tb_slp_burst_ctrl;
  localparam int TW = 16;
  localparam int STOP = 20;
  localparam int NV = 42;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          strap_done_i = 1'b0;
  logic          drain_low_i = 1'b1;
  logic          cond_valid_i = 1'b0;
  logic [TW-1:0] cond_time_i = '0;
  logic [TW-1:0] ton_min_i = 16'd50;   // enter bound 65, exit bound 75
  logic          drive_en_o, skip_cycle_o, force_min_o;
  logic [1:0]    mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  slp_burst_ctrl #(.TW(TW), .STOP_CYC(STOP), .OFF_CYC(15)) dut (
    .clk_i, .rst_ni, .strap_done_i, .drain_low_i, .cond_valid_i,
    .cond_time_i, .ton_min_i, .drive_en_o, .skip_cycle_o, .force_min_o, .mode_o
  );

  // {drain_low, valid, time[15:0], hold[7:0], mode[1:0], drv, skip, force, req[3:0]}
  localparam logic [34:0] VEC [NV] = '{
    {1'b0,1'b1,16'd75, 8'd0, 2'd1,1'b0,1'b0,1'b0,4'd4},  // R4 bound equal
    {1'b1,1'b0,16'd0,  8'd0, 2'd1,1'b0,1'b0,1'b0,4'd4},
    {1'b0,1'b1,16'd76, 8'd0, 2'd0,1'b1,1'b0,1'b0,4'd4},  // R4 exit
    {1'b1,1'b0,16'd0,  8'd0, 2'd0,1'b1,1'b0,1'b0,4'd3},
    {1'b0,1'b1,16'd66, 8'd0, 2'd0,1'b1,1'b0,1'b0,4'd3},  // R3 one above
    {1'b1,1'b0,16'd0,  8'd0, 2'd0,1'b1,1'b0,1'b0,4'd3},
    {1'b0,1'b1,16'd65, 8'd0, 2'd1,1'b0,1'b0,1'b0,4'd3},  // R3 bound equal
    {1'b1,1'b0,16'd0,  8'd0, 2'd1,1'b0,1'b0,1'b0,4'd3},
    {1'b0,1'b1,16'd200,8'd0, 2'd0,1'b1,1'b0,1'b0,4'd4},
    {1'b1,1'b0,16'd0,  8'd0, 2'd0,1'b1,1'b0,1'b0,4'd5},  // R5 restart
    {1'b0,1'b0,16'd0,  8'd17,2'd0,1'b1,1'b0,1'b0,4'd5},  // 18 edges high
    {1'b0,1'b0,16'd0,  8'd0, 2'd0,1'b1,1'b0,1'b0,4'd5},  // 19
    {1'b0,1'b0,16'd0,  8'd0, 2'd2,1'b0,1'b0,1'b0,4'd5},  // 20 -> burst
    {1'b0,1'b1,16'd200,8'd0, 2'd2,1'b0,1'b0,1'b0,4'd9},  // R9
    {1'b1,1'b0,16'd0,  8'd0, 2'd0,1'b0,1'b1,1'b0,4'd6},  // R6 skip
    {1'b0,1'b1,16'd30, 8'd0, 2'd0,1'b1,1'b0,1'b1,4'd6},  // R6 min width, R9
    {1'b1,1'b0,16'd0,  8'd0, 2'd0,1'b1,1'b0,1'b1,4'd6},
    {1'b0,1'b0,16'd0,  8'd0, 2'd0,1'b1,1'b0,1'b0,4'd6},
    {1'b1,1'b0,16'd0,  8'd0, 2'd0,1'b1,1'b0,1'b0,4'd3},
    {1'b0,1'b1,16'd40, 8'd0, 2'd1,1'b0,1'b0,1'b0,4'd3},
    {1'b1,1'b0,16'd0,  8'd0, 2'd1,1'b0,1'b0,1'b0,4'd7},
    {1'b0,1'b0,16'd0,  8'd19,2'd3,1'b0,1'b0,1'b0,4'd7},  // R7 entry
    {1'b1,1'b0,16'd0,  8'd0, 2'd3,1'b0,1'b0,1'b0,4'd7},
    {1'b0,1'b0,16'd0,  8'd0, 2'd3,1'b0,1'b0,1'b0,4'd7},
    {1'b1,1'b0,16'd0,  8'd0, 2'd3,1'b0,1'b0,1'b0,4'd7},
    {1'b0,1'b1,16'd75, 8'd0, 2'd3,1'b0,1'b0,1'b0,4'd7},  // R7 bound equal
    {1'b1,1'b0,16'd0,  8'd0, 2'd3,1'b0,1'b0,1'b0,4'd7},
    {1'b0,1'b1,16'd76, 8'd0, 2'd0,1'b1,1'b0,1'b0,4'd7},  // R7 exit
    {1'b1,1'b0,16'd0,  8'd0, 2'd0,1'b1,1'b0,1'b0,4'd8},
    {1'b0,1'b0,16'd0,  8'd18,2'd0,1'b1,1'b0,1'b0,4'd8},  // 19 edges
    {1'b0,1'b1,16'd10, 8'd0, 2'd2,1'b0,1'b0,1'b0,4'd8},  // R8 stop beats short
    {1'b1,1'b0,16'd0,  8'd0, 2'd0,1'b0,1'b1,1'b0,4'd6},
    {1'b0,1'b0,16'd0,  8'd0, 2'd0,1'b1,1'b0,1'b1,4'd6},
    {1'b1,1'b0,16'd0,  8'd0, 2'd0,1'b1,1'b0,1'b1,4'd6},
    {1'b0,1'b0,16'd0,  8'd0, 2'd0,1'b1,1'b0,1'b0,4'd6},
    {1'b1,1'b0,16'd0,  8'd0, 2'd0,1'b1,1'b0,1'b0,4'd3},
    {1'b0,1'b1,16'd10, 8'd0, 2'd1,1'b0,1'b0,1'b0,4'd3},
    {1'b1,1'b0,16'd0,  8'd0, 2'd1,1'b0,1'b0,1'b0,4'd8},
    {1'b0,1'b0,16'd0,  8'd18,2'd1,1'b0,1'b0,1'b0,4'd8},
    {1'b0,1'b1,16'd200,8'd0, 2'd3,1'b0,1'b0,1'b0,4'd8},  // R8 stop beats long
    {1'b1,1'b0,16'd0,  8'd0, 2'd3,1'b0,1'b0,1'b0,4'd8},
    {1'b0,1'b1,16'd76, 8'd0, 2'd0,1'b1,1'b0,1'b0,4'd8}
  };

  task automatic check(input int req, input logic [1:0] m, input logic d,
                       input logic s, input logic f);
    checks++;
    if (mode_o !== m || drive_en_o !== d || skip_cycle_o !== s || force_min_o !== f) begin
      errors++;
      $display("FAIL R%0d: got mode=%0d drv=%0b skip=%0b min=%0b, exp mode=%0d drv=%0b skip=%0b min=%0b",
               req, mode_o, drive_en_o, skip_cycle_o, force_min_o, m, d, s, f);
    end
  endtask

  task automatic apply(input logic dl, input logic cv, input logic [TW-1:0] ct,
                       input int hold);
    drain_low_i  = dl;
    cond_valid_i = cv;
    cond_time_i  = ct;
    @(negedge clk_i);
    cond_valid_i = 1'b0;
    for (int k = 0; k < hold; k++) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(1, 2'd1, 1'b0, 1'b0, 1'b0);                 // R1 reset state
    rst_ni = 1'b1;
    @(negedge clk_i);
    apply(1'b0, 1'b1, 16'd200, 0);
    check(1, 2'd1, 1'b0, 1'b0, 1'b0);                 // R1 sample ignored before strap
    apply(1'b1, 1'b0, 16'd0, 0);
    strap_done_i = 1'b1;
    @(negedge clk_i);
    check(2, 2'd1, 1'b0, 1'b0, 1'b0);                 // R2 asleep after strap
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][34], VEC[i][33], VEC[i][32:17], int'(VEC[i][16:9]));
      check(int'(VEC[i][3:0]), VEC[i][8:7], VEC[i][6], VEC[i][5], VEC[i][4]);
    end
    rst_ni = 1'b0;
    #1;
    check(1, 2'd1, 1'b0, 1'b0, 1'b0);                 // R1 asynchronous reset from run
    @(negedge clk_i);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, exp completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule